// File: doc/BRIEF.md
# Receive Byte DMA Channel

This block is a single-channel DMA engine that drains the data holding register of a serial receiver into memory, so that incoming bytes reach a buffer without any processor work. Each received byte is latched with a full flag. While the channel is enabled and transfers remain, the full flag raises a request toward a system arbiter, together with a programmable priority level. A one-cycle grant starts a three-step sequence. The first step writes the byte to the current address. The second step increments the address pointer. The third step decrements the remaining-transfer count and releases the holding register.

Software loads a start address and a transfer count, then enables the channel. When the final transfer of a block completes, the channel raises an end-of-block pending flag and turns its own enable off in the same cycle. Software acknowledges the flag by writing one to it. Software may disable the channel at any time. A transfer that is already under way still runs to completion.

Top module: `rxdma_chan`

## Requirements
- R1: `dma_req_o` is high only while the holding register is full, the channel is enabled, the remaining count is nonzero and no transfer sequence is running.
- R2: Once raised, `dma_req_o` stays high until a grant is taken, unless software clears the enable.
- R3: In the cycle after a grant is taken, `mem_we_o` is high for exactly one cycle. During that cycle `mem_addr_o` carries the address register value at the grant and `mem_data_o` carries the held byte.
- R4: Three cycles after the grant edge, the address register has advanced by one, modulo 2^16 (0xFFFF is followed by 0x0000).
- R5: Three cycles after the grant edge, the remaining count has dropped by one and the full flag is clear, unless a new byte arrives in that same cycle.
- R6: When the transfer that takes the count from 1 to 0 completes, the end-of-block pending flag is set and the enable is cleared on the same edge.
- R7: Enabling the channel while the count is zero sets the pending flag at once. The enable stays clear and no request is raised.
- R8: Clearing the enable removes any pending request on the next cycle. A sequence already running still writes, increments and decrements.
- R9: `dma_prio_o` presents the last level written through the priority write port. Its reset value is 0.
- R10: A byte that arrives while the full flag is set, outside the final step of a transfer, sets the sticky overrun flag. The held byte is left unchanged.
- R11: A pulse on `sw_pend_clr_i` clears the pending flag. Setting the flag takes priority over clearing it.
- R12: Software writes to the address or count registers are ignored while a transfer sequence is running.
- R13: A grant that arrives while no request is raised starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_i | input | DATA_W | Byte from the receiver |
| rx_valid_i | input | 1 | One-cycle strobe: a new byte is present |
| sw_addr_wr_i | input | 1 | Load the address register |
| sw_addr_i | input | ADDR_W | Address value to load |
| sw_cnt_wr_i | input | 1 | Load the remaining count |
| sw_cnt_i | input | CNT_W | Count value to load |
| sw_en_set_i | input | 1 | Enable the channel |
| sw_en_clr_i | input | 1 | Disable the channel |
| sw_pend_clr_i | input | 1 | Write-one clear of the pending flag |
| sw_prio_wr_i | input | 1 | Load the priority level |
| sw_prio_i | input | PRIO_W | Priority level to load |
| dma_gnt_i | input | 1 | One-cycle grant from the arbiter |
| dma_req_o | output | 1 | Request to the arbiter |
| dma_prio_o | output | PRIO_W | Priority level presented with the request |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | DATA_W | Memory write data |
| rx_full_o | output | 1 | Holding register full |
| overrun_o | output | 1 | Sticky overrun flag |
| eob_pend_o | output | 1 | End-of-block pending flag |
| dma_en_o | output | 1 | Channel enable state |
| addr_o | output | ADDR_W | Current address register |
| remain_o | output | CNT_W | Remaining transfer count |

## Verification
The bench starts a block at 0xFFFE so the pointer crosses zero. A design that carried past 16 bits or saturated would report the wrong address after the third byte. Enable and register writes are issued in the middle of a running sequence. A design that aborted the sequence, or accepted the writes, would show an unchanged count or a reloaded address. A second byte is forced into a full holding register to check that the first byte is still the one written to memory. A zero-count enable checks that the pending flag rises with no memory write, and a stray grant checks that nothing is written while the channel is idle.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_INC   = 2'd2,
    ST_DEC   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rxdma_rxbuf.sv
// Receive holding register: full flag, sticky overrun, release on consume.
module rxdma_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              consume_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] byte_q;
  logic              full_q;
  logic              ovr_q;
  logic              can_load;

  // A byte may land when empty, or in the cycle the old one is released.
  assign can_load = !full_q || consume_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (valid_i && can_load) begin
        byte_q <= byte_i;
        full_q <= 1'b1;
      end else if (consume_i) begin
        full_q <= 1'b0;
      end
      if (valid_i && !can_load) begin
        ovr_q <= 1'b1;
      end
    end
  end

  assign byte_o = byte_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/rxdma_regs.sv
// Channel registers: pointer, count, enable, pending flag, priority.
module rxdma_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_addr_wr_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic              sw_cnt_wr_i,
  input  logic [CNT_W-1:0]  sw_cnt_i,
  input  logic              sw_en_set_i,
  input  logic              sw_en_clr_i,
  input  logic              sw_pend_clr_i,
  input  logic              sw_prio_wr_i,
  input  logic [PRIO_W-1:0] sw_prio_i,
  input  logic              busy_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              pend_o,
  output logic [PRIO_W-1:0] prio_o
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ZERO = '0;

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q;
  logic              pend_q;
  logic [PRIO_W-1:0] prio_q;
  logic              block_end;
  logic              empty_start;

  assign block_end   = dec_i && (cnt_q == CNT_ONE);
  assign empty_start = sw_en_set_i && (cnt_q == CNT_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (inc_i) begin
      addr_q <= addr_q + 1'b1;
    end else if (sw_addr_wr_i && !busy_i) begin
      addr_q <= sw_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (dec_i) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (sw_cnt_wr_i && !busy_i) begin
      cnt_q <= sw_cnt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      prio_q <= '0;
    end else begin
      if (block_end || sw_en_clr_i) begin
        en_q <= 1'b0;
      end else if (sw_en_set_i && !empty_start) begin
        en_q <= 1'b1;
      end
      if (block_end || empty_start) begin
        pend_q <= 1'b1;
      end else if (sw_pend_clr_i) begin
        pend_q <= 1'b0;
      end
      if (sw_prio_wr_i) begin
        prio_q <= sw_prio_i;
      end
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/rxdma_seq.sv
// Transfer sequencer: grant -> write -> increment -> decrement.
module rxdma_seq
  import rxdma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              want_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_o,
  output logic              busy_o,
  output logic              inc_o,
  output logic              dec_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  seq_state_t        state_q;
  logic              take;
  logic              we_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [DATA_W-1:0] mdata_q;

  assign req_o  = want_i && (state_q == ST_IDLE);
  assign take   = req_o && gnt_i;
  assign busy_o = (state_q != ST_IDLE);
  assign inc_o  = (state_q == ST_INC);
  assign dec_o  = (state_q == ST_DEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (take) state_q <= ST_WRITE;
        ST_WRITE: state_q <= ST_INC;
        ST_INC:   state_q <= ST_DEC;
        ST_DEC:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      maddr_q <= '0;
      mdata_q <= '0;
    end else begin
      we_q <= take;
      if (take) begin
        maddr_q <= addr_i;
        mdata_q <= byte_i;
      end
    end
  end

  assign mem_we_o   = we_q;
  assign mem_addr_o = maddr_q;
  assign mem_data_o = mdata_q;
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_valid_i,
  input  logic              sw_addr_wr_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic              sw_cnt_wr_i,
  input  logic [CNT_W-1:0]  sw_cnt_i,
  input  logic              sw_en_set_i,
  input  logic              sw_en_clr_i,
  input  logic              sw_pend_clr_i,
  input  logic              sw_prio_wr_i,
  input  logic [PRIO_W-1:0] sw_prio_i,
  input  logic              dma_gnt_i,
  output logic              dma_req_o,
  output logic [PRIO_W-1:0] dma_prio_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              rx_full_o,
  output logic              overrun_o,
  output logic              eob_pend_o,
  output logic              dma_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  remain_o
);
  logic [DATA_W-1:0] held_byte;
  logic              full_w;
  logic              busy_w;
  logic              inc_w;
  logic              xfer_done;
  logic              want_w;
  logic [ADDR_W-1:0] addr_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              en_w;

  rxdma_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk       (clk),
    .rst       (rst),
    .byte_i    (rx_byte_i),
    .valid_i   (rx_valid_i),
    .consume_i (xfer_done),
    .byte_o    (held_byte),
    .full_o    (full_w),
    .ovr_o     (overrun_o)
  );

  rxdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .sw_addr_wr_i  (sw_addr_wr_i),
    .sw_addr_i     (sw_addr_i),
    .sw_cnt_wr_i   (sw_cnt_wr_i),
    .sw_cnt_i      (sw_cnt_i),
    .sw_en_set_i   (sw_en_set_i),
    .sw_en_clr_i   (sw_en_clr_i),
    .sw_pend_clr_i (sw_pend_clr_i),
    .sw_prio_wr_i  (sw_prio_wr_i),
    .sw_prio_i     (sw_prio_i),
    .busy_i        (busy_w),
    .inc_i         (inc_w),
    .dec_i         (xfer_done),
    .addr_o        (addr_w),
    .cnt_o         (cnt_w),
    .en_o          (en_w),
    .pend_o        (eob_pend_o),
    .prio_o        (dma_prio_o)
  );

  assign want_w = full_w && en_w && (cnt_w != '0);

  rxdma_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .want_i     (want_w),
    .gnt_i      (dma_gnt_i),
    .byte_i     (held_byte),
    .addr_i     (addr_w),
    .req_o      (dma_req_o),
    .busy_o     (busy_w),
    .inc_o      (inc_w),
    .dec_o      (xfer_done),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o)
  );

  assign rx_full_o = full_w;
  assign dma_en_o  = en_w;
  assign addr_o    = addr_w;
  assign remain_o  = cnt_w;
endmodule

// File: rtl/rxdma_chan_chk.sv
module rxdma_chan_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid_i,
  input logic              sw_en_clr_i,
  input logic              dma_gnt_i,
  input logic              dma_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rx_full_o,
  input logic              overrun_o,
  input logic              eob_pend_o,
  input logic              dma_en_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  remain_o,
  input logic              done_i
);
  p_req_cond_r1: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> (rx_full_o && dma_en_o && remain_o != '0));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (dma_req_o && !dma_gnt_i && !sw_en_clr_i) |=> dma_req_o);

  p_we_after_gnt_r3: assert property (@(posedge clk) disable iff (rst)
    (dma_req_o && dma_gnt_i) |=> mem_we_o);

  p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ##2 (addr_o == ADDR_W'(mem_addr_o + 1'b1)));

  p_pend_off_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(eob_pend_o) |-> !dma_en_o);

  p_overrun_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_full_o && rx_valid_i && !done_i) |=> overrun_o);

  p_hold_regs_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> ($stable(remain_o) && $stable(addr_o)));

  p_stray_gnt_r13: assert property (@(posedge clk) disable iff (rst)
    (!dma_req_o && dma_gnt_i) |=> !mem_we_o);
endmodule

bind rxdma_chan rxdma_chan_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_valid_i  (rx_valid_i),
  .sw_en_clr_i (sw_en_clr_i),
  .dma_gnt_i   (dma_gnt_i),
  .dma_req_o   (dma_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .rx_full_o   (rx_full_o),
  .overrun_o   (overrun_o),
  .eob_pend_o  (eob_pend_o),
  .dma_en_o    (dma_en_o),
  .addr_o      (addr_o),
  .remain_o    (remain_o),
  .done_i      (xfer_done)
);

// File: tb/rxdma_chan_tb_top.sv
`timescale 1ns/1ps
module rxdma_chan_tb_top;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int PRIO_W = 3;

  // vector: start addr[55:40], count[39:24], bytes[23:16], seed[15:8], grant delay[7:0]
  localparam int NVEC = 4;
  localparam logic [55:0] VEC [NVEC] = '{
    {16'h1000, 16'd3, 8'd3, 8'h11, 8'd0},
    {16'hFFFE, 16'd5, 8'd3, 8'hA0, 8'd2},
    {16'h0040, 16'd1, 8'd1, 8'h7F, 8'd1},
    {16'h2000, 16'd4, 8'd2, 8'h00, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] rx_byte_i = '0;
  logic rx_valid_i = 1'b0;
  logic sw_addr_wr_i = 1'b0;
  logic [ADDR_W-1:0] sw_addr_i = '0;
  logic sw_cnt_wr_i = 1'b0;
  logic [CNT_W-1:0] sw_cnt_i = '0;
  logic sw_en_set_i = 1'b0;
  logic sw_en_clr_i = 1'b0;
  logic sw_pend_clr_i = 1'b0;
  logic sw_prio_wr_i = 1'b0;
  logic [PRIO_W-1:0] sw_prio_i = '0;
  logic dma_gnt_i = 1'b0;
  logic dma_req_o;
  logic [PRIO_W-1:0] dma_prio_o;
  logic mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_data_o;
  logic rx_full_o, overrun_o, eob_pend_o, dma_en_o;
  logic [ADDR_W-1:0] addr_o;
  logic [CNT_W-1:0] remain_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rxdma_chan #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W)) dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sw_pulse(input int which, input logic [31:0] val);
    case (which)
      0: begin sw_addr_wr_i = 1'b1; sw_addr_i = val[ADDR_W-1:0]; end
      1: begin sw_cnt_wr_i = 1'b1; sw_cnt_i = val[CNT_W-1:0]; end
      2: sw_en_set_i = 1'b1;
      3: sw_en_clr_i = 1'b1;
      4: sw_pend_clr_i = 1'b1;
      default: begin sw_prio_wr_i = 1'b1; sw_prio_i = val[PRIO_W-1:0]; end
    endcase
    tick();
    sw_addr_wr_i = 1'b0; sw_cnt_wr_i = 1'b0; sw_en_set_i = 1'b0;
    sw_en_clr_i = 1'b0; sw_pend_clr_i = 1'b0; sw_prio_wr_i = 1'b0;
  endtask

  task automatic send_byte(input logic [DATA_W-1:0] b);
    rx_byte_i = b; rx_valid_i = 1'b1;
    tick();
    rx_valid_i = 1'b0;
  endtask

  // Grant and follow the whole sequence, checking the write cycle.
  task automatic grant_xfer(input logic [ADDR_W-1:0] ea, input logic [DATA_W-1:0] ed);
    dma_gnt_i = 1'b1;
    tick();
    dma_gnt_i = 1'b0;
    chk("R3", "write strobe", 32'(mem_we_o), 32'd1);
    chk("R3", "write address", 32'(mem_addr_o), 32'(ea));
    chk("R3", "write data", 32'(mem_data_o), 32'(ed));
    tick();
    chk("R3", "single strobe", 32'(mem_we_o), 32'd0);
    tick();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a0;
    logic [CNT_W-1:0] c0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // reset state
    chk("R1", "reset req", 32'(dma_req_o), 32'd0);
    chk("R3", "reset we", 32'(mem_we_o), 32'd0);
    chk("R10", "reset overrun", 32'(overrun_o), 32'd0);
    chk("R6", "reset pend/en", {30'd0, eob_pend_o, dma_en_o}, 32'd0);
    chk("R9", "reset prio", 32'(dma_prio_o), 32'd0);
    chk("R4", "reset addr", 32'(addr_o), 32'd0);

    // table of blocks
    for (int v = 0; v < NVEC; v++) begin
      logic [55:0] e;
      logic [15:0] sa, sc;
      logic [7:0] nb, sd, dl;
      e = VEC[v];
      {sa, sc, nb, sd, dl} = e;
      sw_pulse(4, 0);
      chk("R11", "pend cleared", 32'(eob_pend_o), 32'd0);
      sw_pulse(0, 32'(sa));
      sw_pulse(1, 32'(sc));
      sw_pulse(2, 0);
      chk("R1", "idle without byte", 32'(dma_req_o), 32'd0);
      for (int i = 0; i < nb; i++) begin
        logic [7:0] b;
        b = sd + 8'(i * 3);
        send_byte(b);
        chk("R1", "req on full", 32'(dma_req_o), 32'd1);
        for (int d = 0; d < dl; d++) begin
          tick();
          chk("R2", "req held", 32'(dma_req_o), 32'd1);
        end
        grant_xfer(sa + 16'(i), b);
        chk("R5", "full released", 32'(rx_full_o), 32'd0);
        chk("R5", "remain", 32'(remain_o), 32'(sc - 16'(i) - 16'd1));
      end
      chk("R4", "end address", 32'(addr_o), 32'(16'(sa + 16'(nb))));
      chk("R6", "pend at end", 32'(eob_pend_o), 32'(nb == sc[7:0]));
      chk("R6", "enable at end", 32'(dma_en_o), 32'(nb != sc[7:0]));
    end

    // R7: zero count enable
    sw_pulse(3, 0);
    sw_pulse(4, 0);
    sw_pulse(1, 0);
    sw_pulse(2, 0);
    chk("R7", "pend on zero enable", 32'(eob_pend_o), 32'd1);
    chk("R7", "enable stays off", 32'(dma_en_o), 32'd0);
    send_byte(8'h5A);
    chk("R7", "no req", 32'(dma_req_o), 32'd0);

    // R13: stray grant
    dma_gnt_i = 1'b1; tick(); dma_gnt_i = 1'b0;
    chk("R13", "no write on stray grant", 32'(mem_we_o), 32'd0);
    chk("R13", "byte still held", 32'(rx_full_o), 32'd1);

    // R10: overrun keeps the first byte
    send_byte(8'hC3);
    chk("R10", "overrun set", 32'(overrun_o), 32'd1);
    sw_pulse(4, 0);
    sw_pulse(0, 32'h0300);
    sw_pulse(1, 32'd2);
    sw_pulse(2, 0);
    grant_xfer(16'h0300, 8'h5A);

    // R9: priority
    sw_pulse(5, 32'd5);
    chk("R9", "prio output", 32'(dma_prio_o), 32'd5);

    // R8: disable while requesting
    send_byte(8'h21);
    chk("R8", "req before clear", 32'(dma_req_o), 32'd1);
    sw_pulse(3, 0);
    chk("R8", "req dropped", 32'(dma_req_o), 32'd0);

    // R8 + R12: disable and register writes during a running sequence
    sw_pulse(0, 32'h0500);
    sw_pulse(1, 32'd3);
    sw_pulse(2, 0);
    a0 = addr_o; c0 = remain_o;
    dma_gnt_i = 1'b1; tick(); dma_gnt_i = 1'b0;
    chk("R3", "write strobe mid test", 32'(mem_we_o), 32'd1);
    sw_en_clr_i = 1'b1; sw_addr_wr_i = 1'b1; sw_addr_i = 16'h7777;
    sw_cnt_wr_i = 1'b1; sw_cnt_i = 16'd9;
    tick();
    sw_en_clr_i = 1'b0; sw_addr_wr_i = 1'b0; sw_cnt_wr_i = 1'b0;
    tick(); tick();
    chk("R12", "addr write ignored", 32'(addr_o), 32'(16'(a0 + 16'd1)));
    chk("R12", "count write ignored", 32'(remain_o), 32'(c0 - 16'd1));
    chk("R8", "enable off after finish", 32'(dma_en_o), 32'd0);
    send_byte(8'h44);
    chk("R8", "no new req", 32'(dma_req_o), 32'd0);

    // R11: set wins over clear is implied; plain clear here
    sw_pulse(4, 0);
    chk("R11", "pend clear", 32'(eob_pend_o), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule